// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. It copies data from a source address region to a destination address region through a simple bus master port. Each transfer is dual-address: the channel reads one or more source operands, packs them into a single destination operand, and then writes that operand. The two address registers and the byte count are loaded while the channel is idle. A transfer sequence then starts from a software start pulse, or from an external request line when that line is enabled.

In cycle-steal mode the channel performs one transfer per request and then returns to idle. In continuous mode a single request runs the channel until the byte count is exhausted. A bandwidth-control field can make a continuous run release the bus each time the remaining count falls on a chosen power-of-two boundary. The channel keeps its request low during the write that lands on the boundary and for one more cycle, then requests the bus again. A bus error, or reaching a count of zero, sets the done flag. A new start is refused until done is cleared.

Top module: `dma_chan`

## Requirements
- R1: After reset the channel is idle: bus_req, bus_cyc, pend, done and berr are 0 and cnt_left is 0.
- R2: A start pulse is accepted only while idle, with done clear and a non-zero count. Acceptance raises pend from the next cycle until the channel returns to idle. A start with a count of zero is ignored.
- R3: A transfer reads the source and then writes the destination. Size codes are 00 = 4 bytes, 01 = 1 byte and 10 = 2 bytes. When the destination is wider, dst/src reads are made, and read k supplies bytes k*src..k*src+src-1 of the write data (least significant first, taken from the low end of bus_rdata). When the source is not narrower, one read is made per write.
- R4: With src_inc set, the source address advances by the source size after each read that completes. With src_inc clear it stays fixed.
- R5: Each completed write lowers cnt_left by the destination size and, with dst_inc set, advances the destination address by the same amount. cnt_left changes at no other time.
- R6: With cfg_cs = 1, each accepted request performs exactly one transfer and the channel then returns to idle with done still clear, unless the count reached zero.
- R7: With cfg_cs = 0, one request runs transfers until cnt_left reaches zero. done is then set and pend drops.
- R8: cfg_bwc codes 1..7 give boundaries of 16, 32, 64, 128, 256, 512 and 1024 bytes; code 0 gives no boundary. In continuous mode, a write that leaves a non-zero count that is a multiple of the boundary is made with bus_req low, and bus_req stays low one further cycle before the bus is requested again.
- R9: A bus_err response to any access sets berr and done, ends the run at once, and leaves cnt_left unchanged by the failed access.
- R10: While done is set, start is ignored. A done_clr pulse clears done and berr.
- R11: ext_req starts the channel like start, but only while cfg_ext_en is 1. With cfg_ext_en at 0 it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cs | input | 1 | 1 = one transfer per request, 0 = continuous |
| cfg_ext_en | input | 1 | Enables the external request line |
| cfg_src_inc | input | 1 | Advance the source address after each read |
| cfg_dst_inc | input | 1 | Advance the destination address after each write |
| cfg_src_sz | input | 2 | Source operand size code |
| cfg_dst_sz | input | 2 | Destination operand size code |
| cfg_bwc | input | 3 | Bandwidth boundary code |
| ld_en | input | 1 | Load address and count registers (idle only) |
| ld_src | input | AW | Source address to load |
| ld_dst | input | AW | Destination address to load |
| ld_cnt | input | CW | Byte count to load |
| start | input | 1 | Internal request pulse |
| ext_req | input | 1 | External request level |
| done_clr | input | 1 | Clears done and berr |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_cyc | output | 1 | Access in progress |
| bus_we | output | 1 | 1 = write access |
| bus_addr | output | AW | Access address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_rdata | input | 32 | Read data, right-justified |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access terminated with an error |
| pend | output | 1 | Request accepted, channel active |
| done | output | 1 | Run finished or stopped by an error |
| berr | output | 1 | Bus error seen |
| cnt_left | output | CW | Remaining byte count |

## Verification
Acceptance is registered, so pend and bus_req are due one cycle after the edge that samples start or ext_req. The bench's responder grants and acknowledges at the falling edge, so each access takes one cycle, and the read count, write addresses and write data of a run are settled once pend has fallen. The bench drives every input at a falling edge and reads every output at a later falling edge. It totals the reads, the writes and the cycles where bus_req is low while the channel is active, and compares them with values worked out from the size, count and boundary rules. A result therefore never depends on sampling at the edge where it changes.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_ARB, ST_RD, ST_WR, ST_GAP} dma_st_e;

  // log2 of operand size: 01 -> byte, 10 -> halfword, 00/11 -> word
  function automatic logic [1:0] sz_lg(input logic [1:0] code);
    case (code)
      2'b01:   return 2'd0;
      2'b10:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [2:0] sz_bytes(input logic [1:0] code);
    return 3'd1 << sz_lg(code);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] code);
    case (code)
      2'b01:   return 32'h0000_00FF;
      2'b10:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [2:0] reads_per(input logic [1:0] src, input logic [1:0] dst);
    logic [1:0] s;
    logic [1:0] d;
    s = sz_lg(src);
    d = sz_lg(dst);
    if (d > s) return 3'd1 << (d - s);
    return 3'd1;
  endfunction

  // 0 -> no boundary, n -> 16 << (n-1) bytes
  function automatic logic [10:0] bwc_span(input logic [2:0] b);
    if (b == 3'd0) return 11'd0;
    return 11'd16 << (b - 3'd1);
  endfunction

  function automatic logic on_boundary(input logic [31:0] cnt, input logic [2:0] b);
    logic [31:0] m;
    m = {21'd0, bwc_span(b)} - 32'd1;
    return (b != 3'd0) && (cnt != 32'd0) && ((cnt & m) == 32'd0);
  endfunction
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic          rd_ok,
  input  logic          wr_ok,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic [1:0]    src_sz,
  input  logic [1:0]    dst_sz,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_after
);
  logic [AW-1:0] src_step;
  logic [AW-1:0] dst_step;

  assign src_step  = AW'(sz_bytes(src_sz));
  assign dst_step  = AW'(sz_bytes(dst_sz));
  assign cnt_after = cnt_q - CW'(sz_bytes(dst_sz));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (ld) begin
      src_q <= ld_src;
      dst_q <= ld_dst;
      cnt_q <= ld_cnt;
    end else begin
      if (rd_ok && src_inc) src_q <= src_q + src_step;
      if (wr_ok) begin
        cnt_q <= cnt_after;
        if (dst_inc) dst_q <= dst_q + dst_step;
      end
    end
  end

  // R5: the count moves only on a completed write (or a load)
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok || ld) |=> $stable(cnt_q));
  p_cnt_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !ld) |=> (cnt_q == $past(cnt_after)));
  // R4: source stays put with increment disabled
  p_src_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !src_inc) |=> $stable(src_q));
endmodule

// File: rtl/dma_pack.sv
module dma_pack
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        rd_ok,
  input  logic        wr_ok,
  input  logic [31:0] rdata,
  input  logic [1:0]  src_sz,
  input  logic [1:0]  dst_sz,
  output logic        last_rd,
  output logic [31:0] wdata
);
  logic [2:0]  idx_q;
  logic [31:0] acc_q;
  logic [4:0]  byte_off;
  logic [7:0]  bit_off;

  always_comb begin
    byte_off = {2'b00, idx_q} << sz_lg(src_sz);
    bit_off  = {byte_off, 3'b000};
  end

  assign last_rd = (idx_q + 3'd1) == reads_per(src_sz, dst_sz);
  assign wdata   = acc_q & lane_mask(dst_sz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (clr || wr_ok) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (rd_ok) begin
      idx_q <= idx_q + 3'd1;
      acc_q <= acc_q | ((rdata & lane_mask(src_sz)) << bit_off);
    end
  end

  // R3: a write never starts with a read slot still open
  p_idx_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (idx_q == 3'd0));
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_int,
  input  logic          go_ext,
  input  logic          ext_en,
  input  logic          cs,
  input  logic [2:0]    bwc,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_after,
  input  logic          last_rd,
  input  logic          bus_gnt,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic          done_clr,
  output dma_st_e       st,
  output logic          accept,
  output logic          rd_ok,
  output logic          wr_ok,
  output logic          bus_req,
  output logic          bus_cyc,
  output logic          done_q,
  output logic          err_q
);
  dma_st_e st_d;
  logic    last_xfer;
  logic    gap_next;
  logic    berr_evt;

  assign bus_cyc   = (st == ST_RD) || (st == ST_WR);
  assign berr_evt  = bus_cyc && bus_err;
  assign rd_ok     = (st == ST_RD) && bus_ack && !bus_err;
  assign wr_ok     = (st == ST_WR) && bus_ack && !bus_err;
  assign last_xfer = (cnt_after == '0);
  assign gap_next  = !cs && !last_xfer && on_boundary(32'(cnt_after), bwc);
  assign accept    = (st == ST_IDLE) && !done_q && (cnt_q != '0) &&
                     (go_int || (ext_en && go_ext));
  assign bus_req   = (st == ST_ARB) || (st == ST_RD) ||
                     ((st == ST_WR) && !gap_next);

  always_comb begin
    st_d = st;
    case (st)
      ST_IDLE: if (accept) st_d = ST_ARB;
      ST_ARB:  if (bus_gnt) st_d = ST_RD;
      ST_RD: begin
        if (berr_evt)               st_d = ST_IDLE;
        else if (rd_ok && last_rd)  st_d = ST_WR;
      end
      ST_WR: begin
        if (berr_evt) st_d = ST_IDLE;
        else if (wr_ok) begin
          if (last_xfer || cs) st_d = ST_IDLE;
          else if (gap_next)   st_d = ST_GAP;
          else                 st_d = ST_RD;
        end
      end
      ST_GAP:  st_d = ST_ARB;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st <= st_d;
      if (berr_evt || (wr_ok && last_xfer)) done_q <= 1'b1;
      else if (done_clr)                    done_q <= 1'b0;
      if (berr_evt)      err_q <= 1'b1;
      else if (done_clr) err_q <= 1'b0;
    end
  end

  p_cs_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && cs) |=> (st == ST_IDLE));
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && gap_next) |=> (!bus_req && st == ST_GAP));
  p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    berr_evt |=> (done_q && err_q && !bus_cyc));
  p_no_run_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !done_q);
  p_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && last_xfer) |=> (done_q && st == ST_IDLE));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cs,
  input  logic          cfg_ext_en,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic [1:0]    cfg_src_sz,
  input  logic [1:0]    cfg_dst_sz,
  input  logic [2:0]    cfg_bwc,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic          start,
  input  logic          ext_req,
  input  logic          done_clr,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  output logic          pend,
  output logic          done,
  output logic          berr,
  output logic [CW-1:0] cnt_left
);
  dma_st_e       st;
  logic          accept, rd_ok, wr_ok, last_rd, ld;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q, cnt_after;

  assign ld       = ld_en && (st == ST_IDLE);
  assign pend     = (st != ST_IDLE);
  assign bus_we   = (st == ST_WR);
  assign bus_addr = bus_we ? dst_q : src_q;
  assign bus_size = bus_we ? cfg_dst_sz : cfg_src_sz;
  assign cnt_left = cnt_q;

  dma_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_int(start), .go_ext(ext_req),
    .ext_en(cfg_ext_en), .cs(cfg_cs), .bwc(cfg_bwc), .cnt_q(cnt_q),
    .cnt_after(cnt_after), .last_rd(last_rd), .bus_gnt(bus_gnt),
    .bus_ack(bus_ack), .bus_err(bus_err), .done_clr(done_clr), .st(st),
    .accept(accept), .rd_ok(rd_ok), .wr_ok(wr_ok), .bus_req(bus_req),
    .bus_cyc(bus_cyc), .done_q(done), .err_q(berr));

  dma_addr_unit #(.AW(AW), .CW(CW)) u_addr (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_src(ld_src), .ld_dst(ld_dst),
    .ld_cnt(ld_cnt), .rd_ok(rd_ok), .wr_ok(wr_ok), .src_inc(cfg_src_inc),
    .dst_inc(cfg_dst_inc), .src_sz(cfg_src_sz), .dst_sz(cfg_dst_sz),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .cnt_after(cnt_after));

  dma_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clr(accept), .rd_ok(rd_ok), .wr_ok(wr_ok),
    .rdata(bus_rdata), .src_sz(cfg_src_sz), .dst_sz(cfg_dst_sz),
    .last_rd(last_rd), .wdata(bus_wdata));

  // R2: an accepted request shows as pend on the next cycle
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pend && bus_req));
  // R11: external line alone never starts the channel while disabled
  p_ext_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !start && !cfg_ext_en) |=> !pend);
endmodule

// File: tb/sim_dma_chan.sv
module sim_dma_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_cs = 0, cfg_ext_en = 0, cfg_src_inc = 0, cfg_dst_inc = 0;
  logic [1:0]  cfg_src_sz = 0, cfg_dst_sz = 0;
  logic [2:0]  cfg_bwc = 0;
  logic        ld_en = 0, start = 0, ext_req = 0, done_clr = 0;
  logic [31:0] ld_src = 0, ld_dst = 0;
  logic [15:0] ld_cnt = 0;
  logic        bus_req, bus_cyc, bus_we, pend, done, berr;
  logic        bus_gnt = 0, bus_ack = 0, bus_err = 0;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = 0;
  logic [1:0]  bus_size;
  logic [15:0] cnt_left;

  dma_chan u0 (.*);

  int total = 0, bad = 0, cyc_n = 0;
  int rd_n = 0, wr_n = 0, low_n = 0;
  logic [31:0] last_rd_addr = 0, last_wr_addr = 0, last_wdata = 0;
  logic err_arm = 0;

  // bus responder and monitor, all at the falling edge
  always @(negedge clk) begin
    if (bus_cyc && !bus_we) begin rd_n++; last_rd_addr = bus_addr; end
    if (bus_cyc && bus_we) begin wr_n++; last_wr_addr = bus_addr; last_wdata = bus_wdata; end
    if (pend && !bus_req) low_n++;
    bus_ack   = bus_cyc && !err_arm;
    bus_err   = bus_cyc && err_arm;
    bus_gnt   = bus_req;
    bus_rdata = {8'hEE, 8'hDD, 8'hCC, bus_addr[7:0]};
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 4;
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 5000 && pend; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] ss, input logic [1:0] ds, input bit si, input bit di,
                       input bit cs, input logic [2:0] bw, input logic [31:0] s,
                       input logic [31:0] d, input logic [15:0] n);
    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0;
    cfg_src_sz = ss; cfg_dst_sz = ds; cfg_src_inc = si; cfg_dst_inc = di;
    cfg_cs = cs; cfg_bwc = bw; ld_src = s; ld_dst = d; ld_cnt = n; ld_en = 1;
    rd_n = 0; wr_n = 0; low_n = 0;
    @(negedge clk); ld_en = 0;
  endtask

  // {src size, dst size, src inc, dst inc, count}
  localparam logic [15:0] VEC [0:5] = '{
    {2'b00, 2'b00, 1'b1, 1'b1, 10'd16},
    {2'b01, 2'b00, 1'b1, 1'b1, 10'd8},
    {2'b10, 2'b00, 1'b1, 1'b0, 10'd12},
    {2'b01, 2'b10, 1'b0, 1'b1, 10'd6},
    {2'b01, 2'b01, 1'b1, 1'b1, 10'd5},
    {2'b00, 2'b01, 1'b1, 1'b1, 10'd3}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!bus_req && !bus_cyc, "R1 bus idle", {bus_req, bus_cyc}, 0);
    chk(!pend && !done && !berr, "R1 status clear", {pend, done, berr}, 0);
    chk(cnt_left == 0, "R1 count", cnt_left, 0);

    // R3 R4 R5 R7 vector table, continuous, no boundary
    foreach (VEC[k]) begin
      logic [1:0] ss, ds; bit si, di; int n, sb, db, rpt, nw, nr;
      {ss, ds, si, di} = VEC[k][15:10];
      n = int'(VEC[k][9:0]);
      sb = nbytes(ss); db = nbytes(ds);
      rpt = (db > sb) ? db / sb : 1;
      nw = n / db; nr = nw * rpt;
      setup(ss, ds, si, di, 0, 0, 32'h100, 32'h800, 16'(n));
      pulse_start();
      wait_idle();
      chk(rd_n == nr, $sformatf("R3 reads vec%0d", k), rd_n, nr);
      chk(wr_n == nw, $sformatf("R7 writes vec%0d", k), wr_n, nw);
      chk(last_rd_addr == (si ? 32'h100 + (nr - 1) * sb : 32'h100),
          $sformatf("R4 src addr vec%0d", k), last_rd_addr, si ? 32'h100 + (nr - 1) * sb : 32'h100);
      chk(last_wr_addr == (di ? 32'h800 + (nw - 1) * db : 32'h800),
          $sformatf("R5 dst addr vec%0d", k), last_wr_addr, di ? 32'h800 + (nw - 1) * db : 32'h800);
      chk(cnt_left == 0 && done && !pend, $sformatf("R7 finished vec%0d", k), {cnt_left, done}, 1);
    end

    // R3 packing byte -> word and halfword -> word
    setup(2'b01, 2'b00, 1, 1, 0, 0, 32'h40, 32'h900, 16'd4);
    pulse_start(); wait_idle();
    chk(last_wdata == 32'h43424140, "R3 byte pack", last_wdata, 32'h43424140);
    setup(2'b10, 2'b00, 1, 1, 0, 0, 32'h60, 32'h900, 16'd4);
    pulse_start(); wait_idle();
    chk(last_wdata == 32'hCC62CC60, "R3 half pack", last_wdata, 32'hCC62CC60);

    // R6 cycle steal
    setup(2'b00, 2'b00, 1, 1, 1, 0, 32'h200, 32'hA00, 16'd12);
    pulse_start(); wait_idle();
    chk(wr_n == 1 && cnt_left == 8, "R6 one transfer", {wr_n[15:0], cnt_left}, {16'd1, 16'd8});
    chk(!done, "R6 done clear", done, 0);
    pulse_start(); wait_idle();
    chk(wr_n == 2 && last_wr_addr == 32'hA04, "R6 second transfer", last_wr_addr, 32'hA04);

    // R8 bandwidth boundaries
    setup(2'b00, 2'b00, 1, 1, 0, 3'd1, 32'h0, 32'h400, 16'd48);
    pulse_start(); wait_idle();
    chk(wr_n == 12, "R8 writes bwc1", wr_n, 12);
    chk(low_n == 4, "R8 gaps bwc1", low_n, 4);
    setup(2'b00, 2'b00, 1, 1, 0, 3'd2, 32'h0, 32'h400, 16'd48);
    pulse_start(); wait_idle();
    chk(low_n == 2, "R8 gaps bwc2", low_n, 2);
    setup(2'b00, 2'b00, 1, 1, 0, 3'd0, 32'h0, 32'h400, 16'd48);
    pulse_start(); wait_idle();
    chk(low_n == 0, "R8 no gaps bwc0", low_n, 0);

    // R2 zero count ignored
    setup(2'b00, 2'b00, 1, 1, 0, 0, 32'h0, 32'h400, 16'd0);
    pulse_start();
    chk(!pend && rd_n == 0, "R2 zero count ignored", pend, 0);

    // R9 bus error
    setup(2'b00, 2'b00, 1, 1, 0, 0, 32'h0, 32'h400, 16'd16);
    err_arm = 1;
    pulse_start(); wait_idle();
    err_arm = 0;
    chk(done && berr, "R9 error flags", {done, berr}, 3);
    chk(cnt_left == 16 && wr_n == 0, "R9 count kept", cnt_left, 16);

    // R10 start ignored while done, then cleared
    rd_n = 0;
    pulse_start();
    chk(!pend && rd_n == 0, "R10 start blocked", pend, 0);
    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0;
    chk(!done && !berr, "R10 cleared", {done, berr}, 0);

    // R11 external request gating, R2 pend timing
    setup(2'b00, 2'b00, 1, 1, 1, 0, 32'h0, 32'h400, 16'd4);
    cfg_ext_en = 0; ext_req = 1;
    repeat (5) @(negedge clk);
    chk(!pend && cnt_left == 4, "R11 ext ignored", pend, 0);
    cfg_ext_en = 1;
    @(negedge clk);
    chk(pend, "R2 ext accepted pend", pend, 1);
    ext_req = 0;
    wait_idle();
    chk(wr_n == 1 && done, "R11 ext transfer", wr_n, 1);
    cfg_ext_en = 0;

    summary();
  end
endmodule